// File: doc/BRIEF.md
# Write Data Delay Window Search Engine

This block steers the search for the usable write data delay window of eight byte lanes that share one test. In each round it asks an external tester for a per-lane error mask. Every lane that has not yet settled then gets one step of its delay line. Lanes cannot be tested or stepped on their own, so all lanes move through the same rounds. The search has two phases. The first walks each lane forward until writes pass. The second keeps walking until writes fail again. Each lane keeps a step count for each edge.

The engine only trusts an edge after ten more confirming steps past it. A lane leaves the active set only when it shows the sought outcome once those ten steps are behind it. When both phases are finished, the engine removes the confirming steps from both edge counts and reports the midpoint of the two counts for each lane. The delay stepper can report an overflow while it is being stepped. An overflow ends the search with an error. Pattern generation and memory access belong to the tester and are not part of this block.

Top module: `wdq_eye_search`

## Requirements
- R1: After reset `test_req`, `step`, `done` and `error` are all low. A `start` pulse seen while idle, finished or in error raises `test_req` on the next clock edge.
- R2: `test_req` stays high until the cycle in which `test_done` is high. `err_mask` is sampled in that same cycle. A mask bit of 1 means that lane failed, and 0 means it passed.
- R3: In the first phase the sought outcome is pass (bit 0). In the second phase it is fail (bit 1). An active lane that does not show the sought outcome gets a one-cycle `step` strobe, and its edge count goes up by one. The strobe appears in the cycle after `test_done`, and `test_req` is low in that cycle.
- R4: An active lane that shows the sought outcome is still stepped and counted until it has made 10 such confirming steps. The next time it shows the sought outcome, it leaves the active set and is not stepped again in that phase.
- R5: A phase ends when no lane is active. The second phase restarts every consistency count at zero, starts each upper count at its final lower count, and continues the delays from where the first phase stopped. With a pass window from step P to step F-1 of at least 11 steps, a lane takes F+10 strobes in total.
- R6: When the second phase ends, `done` rises. `center` lane i (bits 8i+7 down to 8i) then holds floor(((lower-9)+(upper-9))/2). In the terms of R5 this equals floor((P+F+2)/2). `done` and `center` hold until the next `start`.
- R7: If `step_ovf` is high during a cycle with any `step` bit set, `error` rises on the next edge. No further `step` or `test_req` follows until the next `start`.
- R8: `start` clears the lower counts, the consistency counts and the phase. A search run after an aborted one gives the same centres as a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search when not busy |
| test_done | input | 1 | Tester has finished the requested round |
| err_mask | input | 8 | Per-lane result, 1 = lane failed |
| step_ovf | input | 1 | Delay stepper cannot take the current step |
| test_req | output | 1 | Request a test round |
| step | output | 8 | Per-lane one-cycle delay increment strobe |
| done | output | 1 | Search finished, centres valid |
| error | output | 1 | Search aborted on overflow |
| center | output | 64 | Per-lane centre step count, 8 bits per lane |

## Verification
`test_req` is due one edge after `start`, and the step strobes one edge after the `test_done` cycle. The bench model counts a strobe on the edge that ends its cycle and answers each request after zero to two idle cycles. `error` is due one edge after a strobe cycle with `step_ovf` high, and `done` one edge after the last strobe cycle of the second phase. The bench therefore waits for the flag at falling edges and checks the centres, the per-lane strobe totals and the frozen positions only after the flag is seen, leaving 20 further cycles before it checks that nothing has moved.

// File: rtl/wdq_eye_search.sv
`timescale 1ns/1ps
module wdq_eye_search #(
  parameter int LANES   = 8,
  parameter int CONSIST = 10,
  parameter int CW      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                test_done,
  input  logic [LANES-1:0]    err_mask,
  input  logic                step_ovf,
  output logic                test_req,
  output logic [LANES-1:0]    step,
  output logic                done,
  output logic                error,
  output logic [LANES*CW-1:0] center
);
  localparam int CSW = $clog2(CONSIST + 1);
  localparam logic [CW:0] TRIM = (CW+1)'(2 * (CONSIST - 1));

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_STP, S_FIN, S_ERR} state_t;

  state_t            st;
  logic              phase;
  logic [LANES-1:0]  active, step_q;
  logic [CW-1:0]     lo   [LANES];
  logic [CW-1:0]     up   [LANES];
  logic [CSW-1:0]    cons [LANES];
  logic [LANES-1:0]  hit, full, adv, retire;
  logic [CW-1:0]     cen  [LANES];
  logic [LANES*CW-1:0] center_q;

  assign hit = phase ? err_mask : ~err_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CW:0] sum;
    assign full[i]   = (cons[i] == CSW'(CONSIST));
    assign adv[i]    = active[i] & (~hit[i] | ~full[i]);
    assign retire[i] = active[i] & hit[i] & full[i];
    assign sum       = {1'b0, lo[i]} + {1'b0, up[i]} - TRIM;
    assign cen[i]    = sum[CW:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= 1'b0;
      active   <= '0;
      step_q   <= '0;
      center_q <= '0;
      for (int i = 0; i < LANES; i++) begin
        lo[i] <= '0; up[i] <= '0; cons[i] <= '0;
      end
    end else begin
      case (st)
        S_REQ: begin
          if (test_done) begin
            step_q <= adv;
            active <= active & ~retire;
            for (int i = 0; i < LANES; i++) begin
              if (adv[i]) begin
                if (hit[i]) cons[i] <= cons[i] + 1'b1;
                if (phase) up[i] <= up[i] + 1'b1;
                else       lo[i] <= lo[i] + 1'b1;
              end
            end
            st <= S_STP;
          end
        end
        S_STP: begin
          step_q <= '0;
          if ((|step_q) && step_ovf) begin
            st <= S_ERR;
          end else if (active == '0) begin
            if (!phase) begin
              phase  <= 1'b1;
              active <= '1;
              for (int i = 0; i < LANES; i++) begin
                cons[i] <= '0;
                up[i]   <= lo[i];
              end
              st <= S_REQ;
            end else begin
              for (int i = 0; i < LANES; i++) center_q[i*CW +: CW] <= cen[i];
              st <= S_FIN;
            end
          end else begin
            st <= S_REQ;
          end
        end
        default: begin
          step_q <= '0;
          if (start) begin
            st     <= S_REQ;
            phase  <= 1'b0;
            active <= '1;
            for (int i = 0; i < LANES; i++) begin
              lo[i] <= '0; cons[i] <= '0;
            end
          end
        end
      endcase
    end
  end

  assign test_req = (st == S_REQ);
  assign step     = step_q;
  assign done     = (st == S_FIN);
  assign error    = (st == S_ERR);
  assign center   = center_q;
endmodule

module wdq_eye_search_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_done,
  input logic             step_ovf,
  input logic             test_req,
  input logic [LANES-1:0] step,
  input logic             done,
  input logic             error
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> test_req);
  a_r3_step_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0) |=> (step == '0));
  a_r3_no_req_while_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0) |-> !test_req);
  a_r3_step_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0) |-> $past(test_done));
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step == '0 && !test_req && !error));
  a_r7_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
    ((step != '0) && step_ovf) |=> error);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (step == '0 && !test_req));
endmodule

bind wdq_eye_search wdq_eye_search_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_done(test_done), .step_ovf(step_ovf),
  .test_req(test_req), .step(step), .done(done), .error(error)
);

// File: tb/wdq_eye_search_tb.sv
`timescale 1ns/1ps
module wdq_eye_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        test_done = 1'b0;
  logic [7:0]  err_mask = '0;
  logic        step_ovf;
  logic        test_req;
  logic [7:0]  step;
  logic        done, error;
  logic [63:0] center;

  int checks = 0;
  int errors = 0;

  int plo [8];
  int phi [8];
  int plim[8];
  int pos [8];
  logic clr = 1'b0;
  int dly = 0;
  bit req_dropped = 0;

  always #10 clk = ~clk;

  wdq_eye_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_done(test_done),
    .err_mask(err_mask), .step_ovf(step_ovf), .test_req(test_req),
    .step(step), .done(done), .error(error), .center(center)
  );

  logic [7:0] at_lim;
  always_comb for (int i = 0; i < 8; i++) at_lim[i] = (pos[i] >= plim[i]);
  assign step_ovf = |(step & at_lim);

  always @(posedge clk)
    for (int i = 0; i < 8; i++)
      if (clr) pos[i] <= 0;
      else if (step[i]) pos[i] <= pos[i] + 1;

  initial begin
    forever begin
      @(negedge clk);
      if (test_req && !test_done) begin
        repeat (dly) begin
          @(negedge clk);
          if (!test_req) req_dropped = 1;
        end
        dly = (dly + 1) % 3;
        for (int i = 0; i < 8; i++)
          err_mask[i] = (pos[i] < plo[i]) || (pos[i] >= phi[i]);
        test_done = 1'b1;
        @(negedge clk);
        test_done = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lane(input int i, input int lo, input int hi, input int lim);
    plo[i] = lo; phi[i] = hi; plim[i] = lim;
  endtask

  task automatic launch(output bit finished);
    int n = 0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_dropped = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(test_req, "R1 test_req after start", test_req, 1);
    while (!done && !error && n < 5000) begin
      @(negedge clk);
      n++;
    end
    finished = (n < 5000);
    chk(finished, "R1 watchdog", n, 5000);
  endtask

  task automatic check_pass(input string tag);
    bit fin;
    launch(fin);
    chk(done && !error, "R6 done without error", {done, error}, 2);
    chk(!req_dropped, "R2 request held until done", req_dropped, 0);
    for (int i = 0; i < 8; i++) begin
      int expc = (plo[i] + phi[i] + 2) / 2;
      chk(center[i*8 +: 8] == 8'(expc), {tag, " R6 centre"}, center[i*8 +: 8], expc);
      chk(pos[i] == phi[i] + 10, {tag, " R4 R5 strobe total"}, pos[i], phi[i] + 10);
    end
    repeat (4) @(negedge clk);
    chk(done && center[7:0] == 8'((plo[0] + phi[0] + 2) / 2), "R6 done held", done, 1);
  endtask

  task automatic test_reset;
    chk(!test_req && step == 0 && !done && !error, "R1 reset outputs",
        {test_req, step, done, error}, 0);
  endtask

  task automatic test_window_a;
    set_lane(0, 3, 20, 200); set_lane(1, 0, 15, 200);
    set_lane(2, 7, 30, 200); set_lane(3, 12, 25, 200);
    set_lane(4, 5, 40, 200); set_lane(5, 1, 18, 200);
    set_lane(6, 9, 22, 200); set_lane(7, 4, 33, 200);
    check_pass("A");
  endtask

  task automatic test_window_b;
    for (int i = 0; i < 8; i++) set_lane(i, 2 * i, 2 * i + 11 + i, 200);
    set_lane(7, 0, 11, 200);
    check_pass("B");
  endtask

  task automatic test_ovf_phase1;
    bit fin;
    int snap;
    test_window_a_setup();
    plim[3] = 5;
    launch(fin);
    chk(error && !done, "R7 overflow in pass search", {error, done}, 2);
    chk(pos[3] == 6, "R7 overflowing step issued", pos[3], 6);
    snap = pos[0];
    repeat (20) @(negedge clk);
    chk(pos[0] == snap && !test_req && step == 0 && error, "R7 stepping stopped", pos[0], snap);
  endtask

  task automatic test_ovf_phase2;
    bit fin;
    test_window_a_setup();
    plim[0] = 25;
    launch(fin);
    chk(error && !done, "R7 overflow in fail search", {error, done}, 2);
    chk(pos[0] == 26, "R7 phase two overflow position", pos[0], 26);
  endtask

  task automatic test_window_a_setup;
    set_lane(0, 3, 20, 200); set_lane(1, 0, 15, 200);
    set_lane(2, 7, 30, 200); set_lane(3, 12, 25, 200);
    set_lane(4, 5, 40, 200); set_lane(5, 1, 18, 200);
    set_lane(6, 9, 22, 200); set_lane(7, 4, 33, 200);
  endtask

  task automatic test_restart;
    test_window_a_setup();
    check_pass("R8 restart");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin plo[i] = 0; phi[i] = 20; plim[i] = 200; pos[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_window_a();
    test_window_b();
    test_ovf_phase1();
    test_restart();
    test_ovf_phase2();
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule